// File: doc/BRIEF.md
# Banked Word Memory with Three-Level Address Decode

This block is a synthesizable behavioural model of a one-megabit memory that is read and written one 32-bit word at a time. The storage is split into 32 independent banks. Each bank is an array of 128 rows, and each row is 256 bits wide. A 15-bit word address is decoded in three levels. The top level picks the bank. The middle level drives one of 128 row lines inside that bank. The bottom level picks one of the eight 32-bit column groups in the row.

Every request is captured in input registers before it is used. Only the bank that the captured address names is enabled; the other banks do nothing in that cycle, which stands in for switching idle banks off. A write stores the word into one column group of one row. A read fetches the whole row, narrows it to the addressed word through a bank of 8-to-1 column multiplexers, and latches that word in the bank's output register. Each bank drives the shared read bus only in the cycle after it served a read, and the bus floats at all other times. A drive-enable output tells the consumer when the bus carries valid data.

Top module: `sram_banked`

## Requirements
- R1: The word address is split with bank = addr[14:10], row = addr[9:3] and column group = addr[2:0]. Two addresses that differ in only one of these fields refer to separate storage.
- R2: A write (wr_en=1, rd_en=0) replaces the 32 bits of the addressed column group only. The other seven groups of the same row keep their contents.
- R3: A read request presented before rising edge k is captured at edge k. The addressed word is loaded at edge k+1 and appears on rd_data with rd_oe=1 from edge k+1 to edge k+2. rd_oe is 0 between edges k and k+1. Reads may be issued on consecutive cycles.
- R4: In any cycle whose captured request was not a read, rd_oe is 0 and rd_data is high-impedance.
- R5: When rd_en and wr_en are both 1 in the same cycle, the read is served and the write is discarded. The addressed word keeps its old value.
- R6: Each captured request enables at most one bank. The lowest address (0x0000) and the highest address (0x7FFF) are reachable and store data independently.
- R7: While rst_n is 0 and in the first cycle after it returns to 1, rd_oe is 0. Any request pending in the input registers is cleared by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read request, captured on the next rising edge |
| wr_en | input | 1 | Write request, ignored when rd_en is also 1 |
| addr | input | 15 | Word address: bank, row, column group |
| wr_data | input | 32 | Word to store on a write |
| rd_data | output | 32 | Shared read bus, high-impedance when no bank drives it |
| rd_oe | output | 1 | High when a bank drives rd_data with a read result |

## Verification
The assertions assume that rd_en and wr_en are never unknown after reset and that addr is stable whenever a request is captured. The bench meets this by driving every input only on falling clock edges and by giving each input a defined value before reset is released. The assertions also assume that the memory word being read was written earlier. The bench therefore reads only addresses it has already written, and it compares rd_data only while rd_oe is high.

// File: rtl/sram_bank_pkg.sv
package sram_bank_pkg;

  localparam int unsigned DEF_WORD_W = 32;
  localparam int unsigned DEF_BANKS  = 32;
  localparam int unsigned DEF_ROWS   = 128;
  localparam int unsigned DEF_GROUPS = 8;

  // Extracts a field of width w starting at bit lo of a word address.
  function automatic int unsigned addr_field(input int unsigned a,
                                             input int unsigned lo,
                                             input int unsigned w);
    return (a >> lo) & ((32'd1 << w) - 32'd1);
  endfunction

  // Bit offset of a column group inside a row.
  function automatic int unsigned group_base(input int unsigned g,
                                             input int unsigned word_w);
    return g * word_w;
  endfunction

endpackage

// File: rtl/sram_req_reg.sv
module sram_req_reg #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned BANKS  = 32,
  parameter int unsigned BANK_W = 5,
  parameter int unsigned ROW_W  = 7,
  parameter int unsigned GRP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              rd_q,
  output logic              wr_q,
  output logic [ROW_W-1:0]  row_q,
  output logic [GRP_W-1:0]  grp_q,
  output logic [WORD_W-1:0] data_q,
  output logic [BANKS-1:0]  bank_en
);
  import sram_bank_pkg::*;

  logic [ADDR_W-1:0] addr_q;
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      rd_q   <= rd_en;
      wr_q   <= wr_en;
      addr_q <= addr;
      data_q <= wr_data;
    end
  end

  always_comb begin
    grp_q  = GRP_W'(addr_field(32'(addr_q), 0, GRP_W));
    row_q  = ROW_W'(addr_field(32'(addr_q), GRP_W, ROW_W));
    bank_q = BANK_W'(addr_field(32'(addr_q), GRP_W + ROW_W, BANK_W));
  end

  // Top decode level: one enable per bank, active only for a live request.
  for (genvar b = 0; b < BANKS; b++) begin : g_bank_dec
    assign bank_en[b] = (rd_q | wr_q) && (bank_q == BANK_W'(b));
  end

  p_one_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_en));

  p_live_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q | wr_q) |-> ($countones(bank_en) == 1));

endmodule

// File: rtl/sram_bank.sv
module sram_bank #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ROWS   = 128,
  parameter int unsigned GROUPS = 8,
  parameter int unsigned ROW_W  = 7,
  parameter int unsigned GRP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rd,
  input  logic              wr,
  input  logic [ROW_W-1:0]  row,
  input  logic [GRP_W-1:0]  grp,
  input  logic [WORD_W-1:0] wdata,
  output logic              oe,
  output logic [WORD_W-1:0] rdata,
  output logic              rd_fire,
  output logic              wr_fire
);
  import sram_bank_pkg::*;

  localparam int unsigned LINE_W = WORD_W * GROUPS;

  logic [LINE_W-1:0] mem [ROWS];
  logic [ROWS-1:0]   row_hot;
  logic [LINE_W-1:0] line;
  logic [WORD_W-1:0] word;

  // Idle gating: nothing happens in a bank whose enable is low.
  assign rd_fire = en & rd;
  assign wr_fire = en & wr & ~rd;

  // Middle decode level: one row line out of ROWS.
  always_comb begin
    row_hot = '0;
    if (en) row_hot[row] = 1'b1;
  end

  // Row line select as an AND-OR structure driven by the row lines.
  always_comb begin
    line = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (row_hot[r]) line = line | mem[r];
    end
  end

  // Bottom decode level: one GROUPS-to-1 column multiplexer per data bit.
  for (genvar b = 0; b < WORD_W; b++) begin : g_col_mux
    logic [GROUPS-1:0] col;
    for (genvar g = 0; g < GROUPS; g++) begin : g_tap
      assign col[g] = line[group_base(g, WORD_W) + b];
    end
    assign word[b] = col[grp];
  end

  always_ff @(posedge clk) begin
    if (wr_fire) mem[row][group_base(32'(grp), WORD_W) +: WORD_W] <= wdata;
  end

  // Output register, loaded only when this bank serves a read.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe    <= 1'b0;
      rdata <= '0;
    end else begin
      oe <= rd_fire;
      if (rd_fire) rdata <= word;
    end
  end

  p_row_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ($countones(row_hot) == 1));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !oe);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rdata));

endmodule

// File: rtl/sram_bus_merge.sv
module sram_bus_merge #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned BANKS  = 32
) (
  input  logic [BANKS-1:0]  drive,
  input  logic [WORD_W-1:0] word [BANKS],
  output logic              any_drive,
  output logic [WORD_W-1:0] merged
);
  always_comb begin
    merged = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (drive[b]) merged = merged | word[b];
    end
  end

  assign any_drive = |drive;

  always_comb begin
    p_single_driver_r6: assert ($onehot0(drive) || $isunknown(drive));
  end

endmodule

// File: rtl/sram_banked.sv
module sram_banked #(
  parameter int unsigned WORD_W = sram_bank_pkg::DEF_WORD_W,
  parameter int unsigned BANKS  = sram_bank_pkg::DEF_BANKS,
  parameter int unsigned ROWS   = sram_bank_pkg::DEF_ROWS,
  parameter int unsigned GROUPS = sram_bank_pkg::DEF_GROUPS,
  localparam int unsigned BANK_W = $clog2(BANKS),
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned GRP_W  = $clog2(GROUPS),
  localparam int unsigned ADDR_W = BANK_W + ROW_W + GRP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_oe
);
  logic              rd_q, wr_q;
  logic [ROW_W-1:0]  row_q;
  logic [GRP_W-1:0]  grp_q;
  logic [WORD_W-1:0] data_q;
  logic [BANKS-1:0]  bank_en;
  logic [BANKS-1:0]  bank_oe, bank_rd_fire, bank_wr_fire;
  logic [WORD_W-1:0] bank_word [BANKS];
  logic [WORD_W-1:0] merged;

  sram_req_reg #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .BANKS(BANKS),
    .BANK_W(BANK_W), .ROW_W(ROW_W), .GRP_W(GRP_W)
  ) u_req (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data),
    .rd_q(rd_q), .wr_q(wr_q), .row_q(row_q), .grp_q(grp_q),
    .data_q(data_q), .bank_en(bank_en)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    sram_bank #(
      .WORD_W(WORD_W), .ROWS(ROWS), .GROUPS(GROUPS),
      .ROW_W(ROW_W), .GRP_W(GRP_W)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .en(bank_en[b]),
      .rd(rd_q), .wr(wr_q), .row(row_q), .grp(grp_q), .wdata(data_q),
      .oe(bank_oe[b]), .rdata(bank_word[b]),
      .rd_fire(bank_rd_fire[b]), .wr_fire(bank_wr_fire[b])
    );
  end

  sram_bus_merge #(.WORD_W(WORD_W), .BANKS(BANKS)) u_bus (
    .drive(bank_oe), .word(bank_word), .any_drive(rd_oe), .merged(merged)
  );

  // Shared bus: floats whenever no bank output register is driving.
  assign rd_data = rd_oe ? merged : 'z;

  p_read_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !((|bank_rd_fire) && (|bank_wr_fire)));

  p_oe_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_q |=> rd_oe);

  p_bus_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_q |=> !rd_oe);

  p_write_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && !rd_q) |-> ($countones(bank_wr_fire) == 1));

endmodule

// File: tb/sram_banked_test.sv
module sram_banked_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [14:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sram_banked uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_oe(rd_oe)
  );

  // {is_read, address, data or expected word}
  localparam int NVEC = 12;
  localparam logic [47:0] VEC [NVEC] = '{
    {1'b0, 15'h0000, 32'h1111_1111},
    {1'b0, 15'h0400, 32'h2222_2222},
    {1'b0, 15'h0008, 32'h3333_3333},
    {1'b0, 15'h0001, 32'h4444_4444},
    {1'b0, 15'h7FFF, 32'h5555_5555},
    {1'b0, 15'h7FF8, 32'h6666_6666},
    {1'b1, 15'h0000, 32'h1111_1111},
    {1'b1, 15'h0400, 32'h2222_2222},
    {1'b1, 15'h0008, 32'h3333_3333},
    {1'b1, 15'h0001, 32'h4444_4444},
    {1'b1, 15'h7FFF, 32'h5555_5555},
    {1'b1, 15'h7FF8, 32'h6666_6666}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [14:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b0; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Read with full timing check: rd_oe low after capture, word valid one
  // cycle later, rd_oe low again afterwards.
  task automatic do_read(input logic [14:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check({"R3 oe before load ", tag}, {31'd0, rd_oe}, 32'd0);
    @(negedge clk);
    check({"R3 oe at load ", tag}, {31'd0, rd_oe}, 32'd1);
    check(tag, rd_data, exp);
    @(negedge clk);
    check({"R4 oe idle ", tag}, {31'd0, rd_oe}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R7: request pending during reset must not produce a read.
    rd_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 oe during reset", {31'd0, rd_oe}, 32'd0);
    rd_en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 oe first cycle after reset", {31'd0, rd_oe}, 32'd0);

    // R1 / R6: field-isolated addresses and both extreme addresses.
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][47]) do_read(VEC[i][46:32], VEC[i][31:0], $sformatf("R1 R6 read %h", VEC[i][46:32]));
      else            do_write(VEC[i][46:32], VEC[i][31:0]);
    end

    // R2: overwrite group 1 of row 0 bank 0; groups 0 stays.
    do_write(15'h0001, 32'hAAAA_5555);
    do_read(15'h0001, 32'hAAAA_5555, "R2 overwritten group");
    do_read(15'h0000, 32'h1111_1111, "R2 neighbour group kept");
    for (int g = 2; g < 8; g++) do_write(15'(g), 32'hC0DE_0000 + 32'(g));
    do_write(15'h0004, 32'hFACE_0004);
    for (int g = 2; g < 8; g++)
      do_read(15'(g), (g == 4) ? 32'hFACE_0004 : 32'hC0DE_0000 + 32'(g), "R2 row groups");

    // R5: read and write together; write dropped.
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = 15'h0400; wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    check("R5 read served", rd_data, 32'h2222_2222);
    check("R5 oe", {31'd0, rd_oe}, 32'd1);
    do_read(15'h0400, 32'h2222_2222, "R5 write discarded");

    // R3: back-to-back reads from different banks.
    @(negedge clk);
    rd_en = 1'b1; addr = 15'h0000;
    @(negedge clk);
    addr = 15'h7FFF;
    @(negedge clk);
    rd_en = 1'b0;
    check("R3 first of pair", rd_data, 32'h1111_1111);
    @(negedge clk);
    check("R3 second of pair", rd_data, 32'h5555_5555);
    check("R3 oe second", {31'd0, rd_oe}, 32'd1);
    @(negedge clk);
    check("R4 oe after pair", {31'd0, rd_oe}, 32'd0);

    // R4: writes alone never drive the bus.
    @(negedge clk);
    wr_en = 1'b1; addr = 15'h1234; wr_data = 32'h0F0F_0F0F;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    check("R4 oe after write", {31'd0, rd_oe}, 32'd0);
    do_read(15'h1234, 32'h0F0F_0F0F, "R1 mid address");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule